// File: doc/BRIEF.md
# DMA Posted-Write Flush Handshake

This block stands between an ISA/IDE DMA requester and the path to system memory. Posted-write buffers in the system controller may hold data that is newer than main memory. Before a DMA transfer starts, the block therefore asks the controller to drain those buffers, and it grants the transfer only after the controller confirms. The request and the confirmation travel over one shared, tri-stated pin. The block drives a one-clock request pulse on that pin, drives the pin to its inactive level for a short turnaround, then releases it and watches for a one-clock acknowledge pulse from the controller.

When the system keeps memory coherent without draining (buffers that snoop, or no buffers at all), a configuration bit bypasses the exchange and the block acknowledges the request itself. The shared pin is then free. A second configuration bit can put the real-time-clock interrupt on that pin and hide it from the internal interrupt controller. The same bit also hides the interrupt internally in handshake mode, but the pin keeps its handshake role there.

Top module: `dma_flush_hs`

## Requirements
- R1: While reset is active, and after it is released with no DMA request present, the grant is 0, the pin output enable is 0 and the pin output value is the inactive level.
- R2: In handshake mode (bypass bit 0), a DMA request sampled high in the idle state causes the pin to be driven (enable 1) at the active level for exactly one clock, starting one clock after the sampling edge.
- R3: The request pulse is followed by TURN_CYCLES clocks in which the pin is driven (enable 1) at the inactive level. After that the enable drops to 0.
- R4: While the pin is released and awaiting acknowledge, an active level sampled on the pin with the DMA request still high raises the grant one clock later. No grant is given in handshake mode without such an acknowledge.
- R5: The grant stays 1 as long as the DMA request stays high. It falls one clock after the request is sampled low, and the block is idle again.
- R6: If the DMA request has been withdrawn when the acknowledge arrives, the block returns to idle without asserting the grant.
- R7: In bypass mode (bypass bit 1), a DMA request sampled high in idle raises the grant one clock later, and the handshake pulse is never driven. With the interrupt-routing bit 0, the pin enable stays 0.
- R8: In bypass mode with the interrupt-routing bit 1, the pin enable is 1, the pin value follows the RTC interrupt, and the internal interrupt output is 0.
- R9: With the interrupt-routing bit 0, the internal interrupt output follows the RTC interrupt in either mode. In handshake mode with the routing bit 1, the internal interrupt output is 0 and the pin keeps its handshake behaviour.
- R10: The pin level is ignored in every state except the acknowledge wait. This includes the cycles in which the block drives the pin itself. With the pin enable 0, the pin output value is the inactive level. The active level is 1 when PIN_ACTIVE_HIGH is 1 and 0 otherwise.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock of the handshake pin |
| rst_ni | input | 1 | Asynchronous reset, active low |
| dma_req_i | input | 1 | DMA transfer request |
| hs_pin_i | input | 1 | Level sampled on the shared pin |
| rtc_irq_i | input | 1 | Real-time-clock interrupt |
| cfg_bypass_i | input | 1 | 1 = acknowledge internally, pin freed |
| cfg_irq_route_i | input | 1 | 1 = hide RTC interrupt internally (and drive it on the pin in bypass) |
| dma_gnt_o | output | 1 | DMA transfer may proceed |
| hs_pin_o | output | 1 | Value driven on the shared pin |
| hs_pin_oe_o | output | 1 | Output enable of the shared pin |
| rtc_irq_int_o | output | 1 | RTC interrupt toward the internal interrupt controller |

## Verification
The bench builds the block with TURN_CYCLES = 2 and PIN_ACTIVE_HIGH = 1. A two-clock turnaround makes the counter step through a non-final value, so an off-by-one in the turnaround length shows up as a drive-enable mismatch. The bench feeds the pin from a resolved line that carries the block's own drive whenever it is enabled. The block therefore sees its own request pulse as an active level, which puts the ignore rule of R10 under real stress. Configuration changes only in idle, so every mode combination meets both the handshake and the bypass sequences.

// File: rtl/dma_flush_pkg.sv
package dma_flush_pkg;

    typedef enum logic [2:0] {
        FL_IDLE  = 3'd0,
        FL_REQ   = 3'd1,
        FL_TURN  = 3'd2,
        FL_WAIT  = 3'd3,
        FL_GRANT = 3'd4
    } fl_state_e;

endpackage

// File: rtl/dma_flush_fsm.sv
module dma_flush_fsm
    import dma_flush_pkg::*;
#(
    parameter int TURN_CYCLES     = 1,
    parameter bit PIN_ACTIVE_HIGH = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dma_req_i,
    input  logic pin_lvl_i,
    input  logic bypass_i,
    output logic gnt_o,
    output logic drv_en_o,
    output logic drv_val_o
);

    localparam int CNT_W = (TURN_CYCLES > 1) ? $clog2(TURN_CYCLES) : 1;
    localparam logic ACT = PIN_ACTIVE_HIGH;
    localparam logic [CNT_W-1:0] TURN_LAST = CNT_W'(TURN_CYCLES - 1);

    typedef struct packed {
        fl_state_e        st;
        logic [CNT_W-1:0] cnt;
    } fsm_regs_t;

    fsm_regs_t r_d, r_q;
    logic      ack_seen;

    assign ack_seen = (pin_lvl_i == ACT);

    always_comb begin
        r_d = r_q;
        case (r_q.st)
            FL_IDLE: begin
                if (dma_req_i) begin
                    r_d.st = bypass_i ? FL_GRANT : FL_REQ;
                end
            end
            FL_REQ: begin
                r_d.st  = FL_TURN;
                r_d.cnt = '0;
            end
            FL_TURN: begin
                if (r_q.cnt == TURN_LAST) begin
                    r_d.st = FL_WAIT;
                end else begin
                    r_d.cnt = r_q.cnt + 1'b1;
                end
            end
            FL_WAIT: begin
                if (ack_seen) begin
                    r_d.st = dma_req_i ? FL_GRANT : FL_IDLE;
                end
            end
            FL_GRANT: begin
                if (!dma_req_i) begin
                    r_d.st = FL_IDLE;
                end
            end
            default: begin
                r_d.st  = FL_IDLE;
                r_d.cnt = '0;
            end
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) begin
            r_q.st  <= FL_IDLE;
            r_q.cnt <= '0;
        end else begin
            r_q <= r_d;
        end
    end

    assign gnt_o     = (r_q.st == FL_GRANT);
    assign drv_en_o  = (r_q.st == FL_REQ) || (r_q.st == FL_TURN);
    assign drv_val_o = (r_q.st == FL_REQ) ? ACT : ~ACT;

    // R2
    req_pulse_single_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (drv_en_o && drv_val_o == ACT) |=> !(drv_en_o && drv_val_o == ACT));

    // R4
    grant_after_ack_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        ($rose(gnt_o) && !$past(bypass_i)) |->
            ($past(r_q.st) == FL_WAIT && $past(pin_lvl_i) == ACT));

    // R5
    grant_hold_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (gnt_o && dma_req_i) |=> gnt_o);

    // R7
    bypass_grant_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (r_q.st == FL_IDLE && dma_req_i && bypass_i) |=> (gnt_o && !drv_en_o));

endmodule

// File: rtl/dma_flush_pin_route.sv
module dma_flush_pin_route #(
    parameter bit PIN_ACTIVE_HIGH = 1'b1
) (
    input  logic bypass_i,
    input  logic irq_route_i,
    input  logic rtc_irq_i,
    input  logic fsm_en_i,
    input  logic fsm_val_i,
    output logic pin_o,
    output logic pin_oe_o,
    output logic rtc_int_o
);

    localparam logic IDLE_LVL = ~PIN_ACTIVE_HIGH;

    always_comb begin
        pin_oe_o = 1'b0;
        pin_o    = IDLE_LVL;
        if (bypass_i) begin
            if (irq_route_i) begin
                pin_oe_o = 1'b1;
                pin_o    = rtc_irq_i;
            end
        end else if (fsm_en_i) begin
            pin_oe_o = 1'b1;
            pin_o    = fsm_val_i;
        end
        rtc_int_o = irq_route_i ? 1'b0 : rtc_irq_i;
    end

endmodule

// File: rtl/dma_flush_hs.sv
module dma_flush_hs #(
    parameter int TURN_CYCLES     = 1,
    parameter bit PIN_ACTIVE_HIGH = 1'b1
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic dma_req_i,
    input  logic hs_pin_i,
    input  logic rtc_irq_i,
    input  logic cfg_bypass_i,
    input  logic cfg_irq_route_i,
    output logic dma_gnt_o,
    output logic hs_pin_o,
    output logic hs_pin_oe_o,
    output logic rtc_irq_int_o
);

    logic fsm_en, fsm_val;

    dma_flush_fsm #(
        .TURN_CYCLES    (TURN_CYCLES),
        .PIN_ACTIVE_HIGH(PIN_ACTIVE_HIGH)
    ) u_fsm (
        .clk_i    (clk_i),
        .rst_ni   (rst_ni),
        .dma_req_i(dma_req_i),
        .pin_lvl_i(hs_pin_i),
        .bypass_i (cfg_bypass_i),
        .gnt_o    (dma_gnt_o),
        .drv_en_o (fsm_en),
        .drv_val_o(fsm_val)
    );

    dma_flush_pin_route #(
        .PIN_ACTIVE_HIGH(PIN_ACTIVE_HIGH)
    ) u_route (
        .bypass_i   (cfg_bypass_i),
        .irq_route_i(cfg_irq_route_i),
        .rtc_irq_i  (rtc_irq_i),
        .fsm_en_i   (fsm_en),
        .fsm_val_i  (fsm_val),
        .pin_o      (hs_pin_o),
        .pin_oe_o   (hs_pin_oe_o),
        .rtc_int_o  (rtc_irq_int_o)
    );

    // R7
    bypass_pin_quiet_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (cfg_bypass_i && !cfg_irq_route_i) |-> !hs_pin_oe_o);

    // R9
    handshake_no_irq_pin_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
        (!cfg_bypass_i && !fsm_en) |-> !hs_pin_oe_o);

endmodule

// File: tb/dma_flush_hs_tb_top.sv
module dma_flush_hs_tb_top;

    localparam int TB_TURN = 2;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dma_req = 1'b0, rtc = 1'b0, byp = 1'b0, route = 1'b0, ext_pin = 1'b0;
    logic gnt, pin_o, pin_oe, irq_int;
    wire  pin_line;

    int n_chk = 0, n_bad = 0;
    bit done = 1'b0;

    assign pin_line = pin_oe ? pin_o : ext_pin;

    always #5 clk = ~clk;

    dma_flush_hs #(.TURN_CYCLES(TB_TURN), .PIN_ACTIVE_HIGH(1'b1)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .dma_req_i(dma_req), .hs_pin_i(pin_line),
        .rtc_irq_i(rtc), .cfg_bypass_i(byp), .cfg_irq_route_i(route),
        .dma_gnt_o(gnt), .hs_pin_o(pin_o), .hs_pin_oe_o(pin_oe), .rtc_irq_int_o(irq_int)
    );

    // Reference model: 0 idle, 1 request pulse, 2 turnaround, 3 wait ack, 4 grant
    int m_st = 0, m_cnt = 0;

    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_st <= 0; m_cnt <= 0;
        end else begin
            case (m_st)
                0: if (dma_req) m_st <= byp ? 4 : 1;
                1: begin m_st <= 2; m_cnt <= 0; end
                2: if (m_cnt == TB_TURN - 1) m_st <= 3; else m_cnt <= m_cnt + 1;
                3: if (pin_line) m_st <= dma_req ? 4 : 0;
                4: if (!dma_req) m_st <= 0;
                default: m_st <= 0;
            endcase
        end
    end

    function automatic logic exp_oe(int st, logic b, logic r);
        if (b) return r;
        return (st == 1 || st == 2);
    endfunction

    function automatic logic exp_pin(int st, logic b, logic r, logic irq);
        if (b) return r ? irq : 1'b0;
        return (st == 1);
    endfunction

    function automatic string auto_tag(int st, logic b, logic r);
        if (b) return r ? "R8" : "R7";
        case (st)
            1: return "R2";
            2: return "R3";
            3: return "R4";
            4: return "R5";
            default: return r ? "R9" : "R10";
        endcase
    endfunction

    task automatic cmp(string tag, string what, logic act, logic exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%b expected=%b t=%0t", tag, what, act, exp, $time);
        end
    endtask

    task automatic check_all(string tag);
        string t;
        t = (tag == "") ? auto_tag(m_st, byp, route) : tag;
        cmp(t, "gnt", gnt, (m_st == 4));
        cmp(t, "pin_oe", pin_oe, exp_oe(m_st, byp, route));
        cmp(t, "pin_o", pin_o, exp_pin(m_st, byp, route, rtc));
        cmp(route ? "R9" : t, "irq_int", irq_int, route ? 1'b0 : rtc);
    endtask

    task automatic step(string tag);
        @(posedge clk);
        @(negedge clk);
        #1;
        check_all(tag);
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++; n_bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        // R1: reset state
        repeat (3) @(negedge clk);
        #1; check_all("R1");
        rst_n = 1'b1;
        step("R1");

        // R10: pin pulses in idle are ignored
        ext_pin = 1'b1;
        step("R10"); step("R10");
        ext_pin = 1'b0;
        step("R10");

        // R2/R3/R4: directed handshake, ack on first wait cycle
        dma_req = 1'b1;
        step("R2");            // request pulse
        step("R3"); step("R3");
        step("R4");            // waiting
        ext_pin = 1'b1;
        step("R4");            // grant
        ext_pin = 1'b0;
        step("R5");
        dma_req = 1'b0;
        step("R5");            // idle again

        // R6: request withdrawn before the acknowledge
        dma_req = 1'b1;
        step("R6");
        dma_req = 1'b0;
        step("R6"); step("R6"); step("R6");
        ext_pin = 1'b1;
        step("R6");
        ext_pin = 1'b0;
        step("R6"); step("R6");

        // R7: bypass grant one clock after request
        byp = 1'b1; route = 1'b0;
        step("R7");
        dma_req = 1'b1;
        step("R7"); step("R7");
        dma_req = 1'b0;
        step("R7");

        // R8: bypass with interrupt on pin
        route = 1'b1; rtc = 1'b1;
        step("R8");
        rtc = 1'b0;
        step("R8");

        // R9: handshake mode, routing bit set
        byp = 1'b0; rtc = 1'b1;
        step("R9");
        rtc = 1'b0; route = 1'b0;
        step("R9");

        // random phase
        for (int i = 0; i < 6000; i++) begin
            if (m_st == 0 && ($urandom % 16) == 0) begin
                byp = $urandom % 2;
                route = $urandom % 2;
            end
            case (m_st)
                0: if (($urandom % 4) == 0) dma_req = ~dma_req;
                4: if (($urandom % 6) == 0) dma_req = 1'b0;
                default: if (($urandom % 30) == 0) dma_req = ~dma_req;
            endcase
            if (($urandom % 3) == 0) rtc = ~rtc;
            ext_pin = (($urandom % 5) == 0);
            step("");
        end
        finish_run();
    end

endmodule